// File: doc/BRIEF.md
# Port Fault Restart Timer Controller

This block supervises the power switch of one powered network port. It counts how long an overcurrent condition lasts and turns the port off once the condition has lasted longer than a programmable fault time. After such a shutdown it can hold off any new power-on command until a cool-down counter reaches zero. The cool-down length is a programmable multiple of the fault time. This forces a minimum off duty cycle, so that the external pass transistor does not overheat when a load keeps drawing too much current.

Time is counted in ticks of a slow timebase input. A configuration byte, kept outside the block, holds four 2-bit codes: the restart multiple (bits 7:6), the startup time (5:4), the fault time (3:2) and the load-disconnect time (1:0). The block decodes the startup and disconnect codes into tick counts for neighbouring logic. Single-cycle power-on and power-off commands switch the port. A status output shows that a fault has latched, and another shows that a cool-down is still running.

Top module: `port_fault_restart_ctrl`

## Requirements
- R1: After reset, port_pwr, fault_latched and restart_pending are all low.
- R2: With no lockout in force, a one-cycle pwr_on_req turns port_pwr high on the next clock edge.
- R3: A pwr_off_req turns port_pwr low on the next edge, and it wins when it arrives in the same cycle as pwr_on_req.
- R4: While the port is on and overcurrent is high, each tick advances a fault timer. The port turns off at the edge of the F-th such tick. F comes from bits 3:2 of the configuration byte with a nominal value of N=60: code 00 gives N, 01 gives N/2, 10 gives 2N and 11 gives 4N.
- R5: If overcurrent drops for a cycle before the timer expires, the fault timer returns to zero, and a later overcurrent needs a full F ticks to trip.
- R6: A fault shutdown sets fault_latched. The next accepted power-on clears it, and nothing else clears it.
- R7: A fault shutdown loads a lockout counter with M*F ticks, where M comes from bits 7:6: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 0. The counter drops by one on each tick. restart_pending is high while the counter is nonzero.
- R8: While restart_en is high and restart_pending is high, pwr_on_req is ignored. While restart_en is low, pwr_on_req is accepted even during a lockout.
- R9: t_start_ticks gives the startup time from bits 5:4 with a nominal value of 60: code 00 gives 60, 01 gives 30, 10 gives 120 and 11 gives 240.
- R10: t_disc_ticks gives the disconnect time from bits 1:0 with a nominal value of 350: code 00 gives 350, 01 gives 87 (a quarter, truncated), 10 gives 175 and 11 gives 700.
- R11: When the fault timer expires in the same cycle as pwr_on_req or pwr_off_req, the port ends up off, fault_latched goes high and the lockout is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| ovc | input | 1 | Overcurrent flag from the current sense |
| restart_en | input | 1 | Enables power-on refusal during lockout |
| timing_cfg | input | 8 | Restart, startup, fault and disconnect codes |
| pwr_on_req | input | 1 | Power-on command pulse |
| pwr_off_req | input | 1 | Power-off command pulse |
| port_pwr | output | 1 | Port power switch enable |
| fault_latched | output | 1 | Overcurrent shutdown has occurred |
| restart_pending | output | 1 | Lockout counter is nonzero |
| t_start_ticks | output | START_W | Decoded startup duration in ticks |
| t_disc_ticks | output | DISC_W | Decoded disconnect duration in ticks |

## Verification
The port switch has three possible causes of a change, and two of them can act in the same cycle. A command can coincide with another command, or a command can coincide with the expiry of the fault timer. The bench holds overcurrent for exactly F-1 ticks. In the cycle that brings the F-th tick, it raises pwr_on_req or pwr_off_req. The port must end up off, with the fault latched and the lockout pending, because expiry beats the power-on command. The bench also asserts both commands together on a powered port and expects the port to go off.

// File: rtl/prtc_pkg.sv
package prtc_pkg;
   // bit positions of the configuration byte fields
   localparam int RST_LSB   = 6;
   localparam int START_LSB = 4;
   localparam int FAULT_LSB = 2;
   localparam int DISC_LSB  = 0;

   typedef enum logic [1:0] {
      RM_X16 = 2'b00,
      RM_X32 = 2'b01,
      RM_X64 = 2'b10,
      RM_OFF = 2'b11
   } restart_mult_e;

   typedef enum logic [1:0] {
      SC_NOM   = 2'b00,
      SC_HALF  = 2'b01,
      SC_DBL   = 2'b10,
      SC_QUAD  = 2'b11
   } scale_e;
endpackage

// File: rtl/prtc_timing_decode.sv
module prtc_timing_decode
   import prtc_pkg::*;
#(
   parameter int NOM_FAULT_TICKS = 60,
   parameter int NOM_START_TICKS = 60,
   parameter int NOM_DISC_TICKS  = 350,
   parameter int LOCK_W          = 14,
   parameter int START_W         = 8,
   parameter int DISC_W          = 10,
   parameter bit LOCK_BY_SHIFT   = 1'b1
) (
   input  logic [7:0]         cfg,
   output logic [LOCK_W-1:0]  fault_lim,
   output logic [LOCK_W-1:0]  lock_lim,
   output logic [START_W-1:0] start_lim,
   output logic [DISC_W-1:0]  disc_lim
);
   localparam logic [LOCK_W-1:0]  NOM_F = LOCK_W'(NOM_FAULT_TICKS);
   localparam logic [START_W-1:0] NOM_S = START_W'(NOM_START_TICKS);
   localparam logic [DISC_W-1:0]  NOM_D = DISC_W'(NOM_DISC_TICKS);

   scale_e        f_code, s_code;
   logic [1:0]    d_code;
   restart_mult_e r_code;

   assign f_code = scale_e'(cfg[FAULT_LSB +: 2]);
   assign s_code = scale_e'(cfg[START_LSB +: 2]);
   assign d_code = cfg[DISC_LSB +: 2];
   assign r_code = restart_mult_e'(cfg[RST_LSB +: 2]);

   always_comb begin
      unique case (f_code)
         SC_NOM:  fault_lim = NOM_F;
         SC_HALF: fault_lim = NOM_F >> 1;
         SC_DBL:  fault_lim = NOM_F << 1;
         default: fault_lim = NOM_F << 2;
      endcase
   end

   always_comb begin
      unique case (s_code)
         SC_NOM:  start_lim = NOM_S;
         SC_HALF: start_lim = NOM_S >> 1;
         SC_DBL:  start_lim = NOM_S << 1;
         default: start_lim = NOM_S << 2;
      endcase
   end

   always_comb begin
      unique case (d_code)
         2'b00:   disc_lim = NOM_D;
         2'b01:   disc_lim = NOM_D >> 2;
         2'b10:   disc_lim = NOM_D >> 1;
         default: disc_lim = NOM_D << 1;
      endcase
   end

   generate
      if (LOCK_BY_SHIFT) begin : g_shift
         always_comb begin
            unique case (r_code)
               RM_X16:  lock_lim = fault_lim << 4;
               RM_X32:  lock_lim = fault_lim << 5;
               RM_X64:  lock_lim = fault_lim << 6;
               default: lock_lim = '0;
            endcase
         end
      end else begin : g_mult
         logic [6:0] mult;
         always_comb begin
            unique case (r_code)
               RM_X16:  mult = 7'd16;
               RM_X32:  mult = 7'd32;
               RM_X64:  mult = 7'd64;
               default: mult = 7'd0;
            endcase
         end
         assign lock_lim = LOCK_W'(fault_lim * LOCK_W'(mult));
      end
   endgenerate
endmodule

// File: rtl/prtc_fault_timer.sv
module prtc_fault_timer #(
   parameter int LOCK_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ovc,
   input  logic              armed,
   input  logic [LOCK_W-1:0] limit,
   output logic              expire
);
   logic [LOCK_W-1:0] cnt;

   assign expire = armed & ovc & tick & (cnt + LOCK_W'(1) >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !armed || !ovc) cnt <= '0;
      else if (tick)                cnt <= cnt + LOCK_W'(1);
   end
endmodule

// File: rtl/prtc_restart_timer.sv
module prtc_restart_timer #(
   parameter int LOCK_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [LOCK_W-1:0] load_val,
   output logic              busy
);
   logic [LOCK_W-1:0] cnt;

   assign busy = |cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (tick && busy) cnt <= cnt - LOCK_W'(1);
   end
endmodule

// File: rtl/port_fault_restart_ctrl.sv
module port_fault_restart_ctrl #(
   parameter int NOM_FAULT_TICKS = 60,
   parameter int NOM_START_TICKS = 60,
   parameter int NOM_DISC_TICKS  = 350,
   parameter bit LOCK_BY_SHIFT   = 1'b1,
   parameter int START_W = $clog2(4 * NOM_START_TICKS + 1),
   parameter int DISC_W  = $clog2(2 * NOM_DISC_TICKS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               ovc,
   input  logic               restart_en,
   input  logic [7:0]         timing_cfg,
   input  logic               pwr_on_req,
   input  logic               pwr_off_req,
   output logic               port_pwr,
   output logic               fault_latched,
   output logic               restart_pending,
   output logic [START_W-1:0] t_start_ticks,
   output logic [DISC_W-1:0]  t_disc_ticks
);
   localparam int LOCK_W = $clog2(256 * NOM_FAULT_TICKS + 1);

   generate
      if (NOM_FAULT_TICKS < 2 || (NOM_FAULT_TICKS % 2) != 0) begin : g_bad_fault
         $error("NOM_FAULT_TICKS must be even and at least 2");
      end
      if (NOM_START_TICKS < 2 || (NOM_START_TICKS % 2) != 0) begin : g_bad_start
         $error("NOM_START_TICKS must be even and at least 2");
      end
      if (NOM_DISC_TICKS < 4) begin : g_bad_disc
         $error("NOM_DISC_TICKS must be at least 4");
      end
   endgenerate

   logic [LOCK_W-1:0] fault_lim, lock_lim;
   logic              expire, lock_busy, on_ok, on_take;

   prtc_timing_decode #(
      .NOM_FAULT_TICKS (NOM_FAULT_TICKS),
      .NOM_START_TICKS (NOM_START_TICKS),
      .NOM_DISC_TICKS  (NOM_DISC_TICKS),
      .LOCK_W          (LOCK_W),
      .START_W         (START_W),
      .DISC_W          (DISC_W),
      .LOCK_BY_SHIFT   (LOCK_BY_SHIFT)
   ) u_dec (
      .cfg       (timing_cfg),
      .fault_lim (fault_lim),
      .lock_lim  (lock_lim),
      .start_lim (t_start_ticks),
      .disc_lim  (t_disc_ticks)
   );

   prtc_fault_timer #(.LOCK_W(LOCK_W)) u_ft (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .ovc    (ovc),
      .armed  (port_pwr),
      .limit  (fault_lim),
      .expire (expire)
   );

   prtc_restart_timer #(.LOCK_W(LOCK_W)) u_rt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (expire),
      .load_val (lock_lim),
      .busy     (lock_busy)
   );

   assign restart_pending = lock_busy;
   assign on_ok   = !restart_en || !lock_busy;
   assign on_take = pwr_on_req && !pwr_off_req && !expire && on_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_pwr      <= 1'b0;
         fault_latched <= 1'b0;
      end else begin
         if (pwr_off_req || expire) port_pwr <= 1'b0;
         else if (on_take)          port_pwr <= 1'b1;

         if (expire)       fault_latched <= 1'b1;
         else if (on_take) fault_latched <= 1'b0;
      end
   end
endmodule

// File: rtl/prtc_chk.sv
module prtc_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic restart_en,
   input logic pwr_on_req,
   input logic pwr_off_req,
   input logic port_pwr,
   input logic fault_latched,
   input logic restart_pending
);
   // R3: an off command always leaves the port off
   a_r3_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_off_req |=> !port_pwr);

   // R8: no power-up while the lockout is enforced
   a_r8_lockout_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_en && restart_pending && !port_pwr) |=> !port_pwr);

   // R2: the port only rises after a power-on command
   a_r2_rise_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_pwr) |-> $past(pwr_on_req));

   // R6: a drop not caused by an off command is a fault shutdown
   a_r6_fault_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(port_pwr) && !$past(pwr_off_req)) |-> fault_latched);

   // R6: the latch holds until a power-on command
   a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched && !pwr_on_req) |=> fault_latched);

   // R7: the lockout only moves on a tick while the port is off
   a_r7_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_pwr && !tick) |=> $stable(restart_pending));
endmodule

bind port_fault_restart_ctrl prtc_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .tick            (tick),
   .restart_en      (restart_en),
   .pwr_on_req      (pwr_on_req),
   .pwr_off_req     (pwr_off_req),
   .port_pwr        (port_pwr),
   .fault_latched   (fault_latched),
   .restart_pending (restart_pending)
);

// File: tb/sim_port_fault_restart_ctrl.sv
module sim_port_fault_restart_ctrl;
   logic       clk = 1'b0;
   logic       rst_n, tick, ovc, restart_en, pwr_on_req, pwr_off_req;
   logic [7:0] timing_cfg;
   logic       port_pwr, fault_latched, restart_pending;
   logic [7:0] t_start_ticks;
   logic [9:0] t_disc_ticks;
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   port_fault_restart_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ovc(ovc),
      .restart_en(restart_en), .timing_cfg(timing_cfg),
      .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
      .port_pwr(port_pwr), .fault_latched(fault_latched),
      .restart_pending(restart_pending),
      .t_start_ticks(t_start_ticks), .t_disc_ticks(t_disc_ticks)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic do_reset(input logic [7:0] cfg, input logic ren);
      rst_n = 1'b0; tick = 0; ovc = 0; pwr_on_req = 0; pwr_off_req = 0;
      restart_en = ren; timing_cfg = cfg;
      step(); step();
      rst_n = 1'b1;
   endtask

   task automatic power_on();
      pwr_on_req = 1'b1; step(); pwr_on_req = 1'b0;
   endtask

   function automatic int fault_of(input logic [7:0] cfg);
      case (cfg[3:2]) 2'b00: return 60; 2'b01: return 30;
                      2'b10: return 120; default: return 240; endcase
   endfunction

   function automatic int mult_of(input logic [7:0] cfg);
      case (cfg[7:6]) 2'b00: return 16; 2'b01: return 32;
                      2'b10: return 64; default: return 0; endcase
   endfunction

   // ovc with ticks for n cycles
   task automatic ovc_ticks(input int n);
      ovc = 1'b1; tick = 1'b1;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic t_reset_state();
      do_reset(8'h00, 1'b1);
      check("R1 port_pwr", port_pwr, 0);
      check("R1 fault_latched", fault_latched, 0);
      check("R1 restart_pending", restart_pending, 0);
   endtask

   task automatic t_on_off();
      do_reset(8'h00, 1'b1);
      power_on();
      check("R2 port on", port_pwr, 1);
      pwr_off_req = 1'b1; step(); pwr_off_req = 1'b0;
      check("R3 port off", port_pwr, 0);
      check("R3 no fault on command off", fault_latched, 0);
      power_on();
      pwr_on_req = 1'b1; pwr_off_req = 1'b1; step();
      pwr_on_req = 1'b0; pwr_off_req = 1'b0;
      check("R3 off wins on same cycle", port_pwr, 0);
      pwr_on_req = 1'b1; pwr_off_req = 1'b1; step();
      pwr_on_req = 1'b0; pwr_off_req = 1'b0;
      check("R3 off wins from off", port_pwr, 0);
   endtask

   task automatic t_trip(input logic [7:0] cfg);
      int f = fault_of(cfg);
      do_reset(cfg, 1'b1);
      power_on();
      ovc_ticks(f - 1);
      check("R4 still on at F-1", port_pwr, 1);
      ovc_ticks(1);
      ovc = 1'b0; tick = 1'b0;
      check("R4 off at F", port_pwr, 0);
      check("R6 fault latched", fault_latched, 1);
   endtask

   task automatic t_ovc_glitch();
      do_reset(8'h04, 1'b1);
      power_on();
      ovc_ticks(29);
      ovc = 1'b0; step();
      ovc_ticks(29);
      check("R5 timer cleared by ovc drop", port_pwr, 1);
      ovc_ticks(1);
      ovc = 1'b0; tick = 1'b0;
      check("R5 trips after full F", port_pwr, 0);
   endtask

   task automatic t_lockout(input logic [7:0] cfg);
      int l = mult_of(cfg) * fault_of(cfg);
      t_trip(cfg);
      if (l == 0) begin
         check("R7 code 11 no lockout", restart_pending, 0);
         power_on();
         check("R8 on right away with no lockout", port_pwr, 1);
         return;
      end
      check("R7 pending after trip", restart_pending, 1);
      tick = 1'b1;
      for (int i = 0; i < l - 1; i++) step();
      tick = 1'b0;
      check("R7 pending at L-1", restart_pending, 1);
      power_on();
      check("R8 refused during lockout", port_pwr, 0);
      check("R6 latch kept after refusal", fault_latched, 1);
      tick = 1'b1; step(); tick = 1'b0;
      check("R7 pending clear at L", restart_pending, 0);
      power_on();
      check("R8 accepted after lockout", port_pwr, 1);
      check("R6 latch cleared by power-on", fault_latched, 0);
   endtask

   task automatic t_no_restart_en();
      do_reset(8'h04, 1'b0);
      power_on();
      ovc_ticks(30);
      ovc = 1'b0; tick = 1'b0;
      check("R8 pending with enable low", restart_pending, 1);
      power_on();
      check("R8 accepted with enable low", port_pwr, 1);
      check("R6 cleared with enable low", fault_latched, 0);
   endtask

   task automatic t_collide(input bit use_off);
      do_reset(8'h04, 1'b1);
      power_on();
      ovc_ticks(29);
      if (use_off) pwr_off_req = 1'b1; else pwr_on_req = 1'b1;
      ovc_ticks(1);
      pwr_on_req = 1'b0; pwr_off_req = 1'b0; ovc = 1'b0; tick = 1'b0;
      check("R11 port off on expiry collision", port_pwr, 0);
      check("R11 fault latched on collision", fault_latched, 1);
      check("R11 lockout loaded on collision", restart_pending, 1);
   endtask

   task automatic t_decode();
      int se[4] = '{60, 30, 120, 240};
      int de[4] = '{350, 87, 175, 700};
      for (int c = 0; c < 4; c++) begin
         timing_cfg = {2'b00, 2'(c), 2'b00, 2'(3 - c)};
         #1;
         check("R9 startup decode", int'(t_start_ticks), se[c]);
         check("R10 disconnect decode", int'(t_disc_ticks), de[3 - c]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_on_off();
      t_trip(8'h00);
      t_trip(8'h04);
      t_trip(8'h08);
      t_trip(8'h0C);
      t_ovc_glitch();
      t_lockout(8'h04);
      t_lockout(8'h44);
      t_lockout(8'h84);
      t_lockout(8'hC4);
      t_no_restart_en();
      t_collide(1'b0);
      t_collide(1'b1);
      t_decode();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule